// File: doc/BRIEF.md
# Decimating Programmable FIR Engine

This block is a time-shared FIR filter. It takes signed 24-bit samples, one per `in_valid` strobe, and stores every one of them in a circular delay memory. On every D-th accepted sample it runs one multiply-accumulate pass over the N newest samples. D is programmable from 1 to 8, and N from 1 to 256. The pass produces a single rounded and saturated 24-bit result with a one-cycle valid strobe. Each pass uses one multiplier and takes one clock cycle per tap.

A host loads the 32-bit coefficients and the two configuration fields through a byte-wide register port with four registers. Any register can be read back through the same port. A coefficient is formed from four byte accesses, least significant byte first, to a data register. That register advances a shared byte pointer on every write and on every read. Coefficients are signed fractions with 31 fraction bits, so `0x40000000` stands for 0.5.

If a sample arrives while a pass is still running, a sticky overrun flag is raised. The flag can be seen on a port and in a register bit. A write to the decimation register clears it.

Top module: `decim_fir`

## Requirements
- R1: After reset, `out_valid` and `overrun` are 0, all coefficients and stored samples are zero, and the tap field and the decimation field both read 0, which means N=1 and D=1.
- R2: The host registers are selected by `host_addr`: 0 is the tap pointer, 1 holds N-1, 2 holds D-1 in bits [2:0], and 3 is the coefficient data byte. Writing address 0 sets the tap pointer and selects byte 0. Each write to address 3 stores the byte into the selected byte of the selected coefficient, least significant byte first. After byte 3 the pointer moves on to byte 0 of the next tap.
- R3: A read (`host_cs`=1, `host_we`=0) returns its byte on `host_rdata` from the next clock edge on. A read of address 3 returns the coefficient bytes in the order they were written and advances the same pointer. A read of address 0 returns the tap pointer. A read of address 2 returns D-1 in bits [2:0] and the overrun flag in bit 7.
- R4: A pass starts only on the D-th sample counted since reset or since the last write to address 2. Other samples produce no output.
- R5: The result equals the sum over k=0..N-1 of c[k]·x[n-k], where x[n] is the newest sample. Samples that were never written count as zero.
- R6: The sum is scaled by 2^-31 and rounded to nearest, with exact halves going toward +infinity. It is then saturated to the range -8388608..8388607.
- R7: `out_valid` pulses for exactly one cycle. It rises N clock edges after the edge that accepted the triggering sample.
- R8: A sample accepted while a pass is busy sets `overrun`. The flag stays set until a write to address 2 clears it. Such a sample is still stored and still counts toward D, but it starts no pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | 24 | Signed input sample |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Host register select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, registered |
| out_valid | output | 1 | One-cycle result strobe |
| out_sample | output | 24 | Rounded, saturated result |
| overrun | output | 1 | Sticky overrun flag |

## Verification
Random samples and scaled random coefficients at N=8 and at N=256 with D=8 exercise the whole tap walk. These runs separate a correct ring address and tap order from shifted or reversed ones. Directed half-coefficient samples (±1, ±3) separate round-half-up from truncation and from symmetric rounding. Full-scale pairs drive both saturation limits. A D=3 run, including a decimation register rewrite partway through a phase, shows which samples may trigger a pass. Back-to-back samples separate the sticky overrun behaviour from a pass that is simply late.

// File: rtl/dfir_pkg.sv
package dfir_pkg;
    localparam int DATA_W   = 24;
    localparam int COEF_W   = 32;
    localparam int TAP_MAX  = 256;
    localparam int DEC_MAX  = 8;
    localparam int HOST_W   = 8;
    localparam int TAP_AW   = $clog2(TAP_MAX);
    localparam int DEC_AW   = $clog2(DEC_MAX);
    localparam int LANES    = COEF_W / HOST_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int PROD_W   = DATA_W + COEF_W;
    localparam int ACC_W    = PROD_W + TAP_AW;
    localparam int FRAC     = COEF_W - 1;

    typedef enum logic [1:0] {
        REG_PTR   = 2'd0,
        REG_TAPS  = 2'd1,
        REG_DECIM = 2'd2,
        REG_COEF  = 2'd3
    } hreg_e;

    typedef struct packed {
        logic [TAP_AW-1:0] taps_m1;
        logic [DEC_AW-1:0] decim_m1;
    } cfg_t;

    localparam logic signed [ACC_W-1:0] OUT_MAX =
        {{(ACC_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] OUT_MIN =
        {{(ACC_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] RND_HALF =
        {{(ACC_W-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

    // Scale by 2^-FRAC, round half toward +inf, clamp to signed DATA_W.
    function automatic logic [DATA_W-1:0] round_sat(input logic signed [ACC_W-1:0] a);
        logic signed [ACC_W-1:0] r;
        r = (a + RND_HALF) >>> FRAC;
        if (r > OUT_MAX)      r = OUT_MAX;
        else if (r < OUT_MIN) r = OUT_MIN;
        return r[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/dfir_host_port.sv
module dfir_host_port
    import dfir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    input  logic              overrun,
    input  logic [TAP_AW-1:0] coef_idx,
    output logic [COEF_W-1:0] coef_word,
    output cfg_t              cfg,
    output logic              cfg_wr
);
    logic [COEF_W-1:0] coef_mem [TAP_MAX];
    logic [TAP_AW-1:0] tap_ptr;
    logic [LANE_W-1:0] lane;
    hreg_e             sel;
    logic              wr_en, rd_en, coef_acc;
    logic [COEF_W-1:0] cur_word;

    assign sel       = hreg_e'(host_addr);
    assign wr_en     = host_cs && host_we;
    assign rd_en     = host_cs && !host_we;
    assign coef_acc  = host_cs && (sel == REG_COEF);
    assign cfg_wr    = wr_en && (sel == REG_DECIM);
    assign coef_word = coef_mem[coef_idx];
    assign cur_word  = coef_mem[tap_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            tap_ptr    <= '0;
            lane       <= '0;
            cfg        <= '0;
            host_rdata <= '0;
        end else begin
            if (wr_en) begin
                unique case (sel)
                    REG_PTR:   begin tap_ptr <= host_wdata[TAP_AW-1:0]; lane <= '0; end
                    REG_TAPS:  cfg.taps_m1  <= host_wdata[TAP_AW-1:0];
                    REG_DECIM: cfg.decim_m1 <= host_wdata[DEC_AW-1:0];
                    default:   ;
                endcase
            end
            if (rd_en) begin
                unique case (sel)
                    REG_PTR:   host_rdata <= HOST_W'(tap_ptr);
                    REG_TAPS:  host_rdata <= HOST_W'(cfg.taps_m1);
                    REG_DECIM: host_rdata <= {overrun, (HOST_W-1)'(cfg.decim_m1)};
                    REG_COEF:  host_rdata <= cur_word[lane*HOST_W +: HOST_W];
                endcase
            end
            if (coef_acc) begin
                lane <= lane + 1'b1;
                if (lane == LANE_W'(LANES-1)) tap_ptr <= tap_ptr + 1'b1;
            end
        end
    end

    // One byte lane per generate branch of the coefficient store.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int t = 0; t < TAP_MAX; t++) coef_mem[t][g*HOST_W +: HOST_W] <= '0;
            end else if (wr_en && coef_acc && lane == LANE_W'(g)) begin
                coef_mem[tap_ptr][g*HOST_W +: HOST_W] <= host_wdata;
            end
        end
    end

    // R2: the last byte of a tap moves the pointer to byte 0 of the next tap
    a_r2_lane_wrap: assert property (@(posedge clk) disable iff (rst)
        coef_acc && lane == LANE_W'(LANES-1) |=> lane == '0 && tap_ptr == TAP_AW'($past(tap_ptr) + 1'b1));
    // R2: setting the pointer selects byte 0
    a_r2_ptr_set: assert property (@(posedge clk) disable iff (rst)
        wr_en && sel == REG_PTR |=> lane == '0 && tap_ptr == $past(host_wdata[TAP_AW-1:0]));
endmodule

// File: rtl/dfir_sample_ram.sv
module dfir_sample_ram
    import dfir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic [TAP_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [TAP_AW-1:0] wr_ptr
);
    logic [DATA_W-1:0] mem [TAP_MAX];

    assign rd_data = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            for (int i = 0; i < TAP_MAX; i++) mem[i] <= '0;
        end else if (in_valid) begin
            mem[wr_ptr] <= in_sample;
            wr_ptr      <= wr_ptr + 1'b1;
        end
    end

    // R8: every accepted sample is stored, busy or not
    a_r8_store_all: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> wr_ptr == TAP_AW'($past(wr_ptr) + 1'b1));
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(wr_ptr));
endmodule

// File: rtl/dfir_mac.sv
module dfir_mac
    import dfir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [TAP_AW-1:0] wr_ptr,
    input  cfg_t              cfg,
    input  logic              cfg_wr,
    input  logic [COEF_W-1:0] coef_word,
    input  logic [DATA_W-1:0] samp_word,
    output logic [TAP_AW-1:0] coef_idx,
    output logic [TAP_AW-1:0] samp_idx,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic              overrun
);
    logic                     busy;
    logic [TAP_AW-1:0]        tap_idx, taps_l, base;
    logic [DEC_AW-1:0]        dcnt;
    logic signed [ACC_W-1:0]  acc, acc_nxt;
    logic signed [PROD_W-1:0] prod;
    logic                     start, last;

    assign start    = in_valid && !busy && (dcnt == cfg.decim_m1);
    assign last     = busy && (tap_idx == taps_l);
    assign coef_idx = tap_idx;
    assign samp_idx = base - tap_idx;
    assign prod     = $signed(coef_word) * $signed(samp_word);
    assign acc_nxt  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            tap_idx    <= '0;
            taps_l     <= '0;
            base       <= '0;
            acc        <= '0;
            dcnt       <= '0;
            out_valid  <= 1'b0;
            out_sample <= '0;
            overrun    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            overrun   <= (overrun && !cfg_wr) || (in_valid && busy);
            if (cfg_wr)        dcnt <= '0;
            else if (in_valid) dcnt <= (dcnt == cfg.decim_m1) ? '0 : dcnt + 1'b1;
            if (start) begin
                busy    <= 1'b1;
                tap_idx <= '0;
                taps_l  <= cfg.taps_m1;
                base    <= wr_ptr;
                acc     <= '0;
            end else if (last) begin
                busy       <= 1'b0;
                out_valid  <= 1'b1;
                out_sample <= round_sat(acc_nxt);
            end else if (busy) begin
                tap_idx <= tap_idx + 1'b1;
                acc     <= acc_nxt;
            end
        end
    end

    // R7: result strobe lasts one cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
    // R7: the tap walk never passes the latched tap count
    a_r7_idx_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> tap_idx <= taps_l);
    // R4: a pass begins at tap zero
    a_r4_start: assert property (@(posedge clk) disable iff (rst)
        start |=> busy && tap_idx == '0);
    // R8: a sample during a pass raises the flag
    a_r8_set: assert property (@(posedge clk) disable iff (rst)
        in_valid && busy |=> overrun);
    // R8: the flag holds until a decimation write
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun && !cfg_wr |=> overrun);
endmodule

// File: rtl/decim_fir.sv
module decim_fir
    import dfir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              host_cs,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [HOST_W-1:0] host_rdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_sample,
    output logic              overrun
);
    cfg_t              cfg;
    logic              cfg_wr;
    logic [TAP_AW-1:0] coef_idx, samp_idx, wr_ptr;
    logic [COEF_W-1:0] coef_word;
    logic [DATA_W-1:0] samp_word;

    dfir_host_port u_host (
        .clk(clk), .rst(rst), .host_cs(host_cs), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .overrun(overrun), .coef_idx(coef_idx), .coef_word(coef_word),
        .cfg(cfg), .cfg_wr(cfg_wr)
    );

    dfir_sample_ram u_ram (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .rd_idx(samp_idx), .rd_data(samp_word), .wr_ptr(wr_ptr)
    );

    dfir_mac u_mac (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wr_ptr(wr_ptr), .cfg(cfg),
        .cfg_wr(cfg_wr), .coef_word(coef_word), .samp_word(samp_word),
        .coef_idx(coef_idx), .samp_idx(samp_idx), .out_valid(out_valid),
        .out_sample(out_sample), .overrun(overrun)
    );
endmodule

// File: tb/decim_fir_test.sv
module decim_fir_test;
    logic        clk = 1'b0;
    logic        rst, in_valid, host_cs, host_we;
    logic [23:0] in_sample, out_sample;
    logic [1:0]  host_addr;
    logic [7:0]  host_wdata, host_rdata;
    logic        out_valid, overrun;

    always #5 clk = ~clk;

    decim_fir uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .out_valid(out_valid), .out_sample(out_sample), .overrun(overrun)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] coef_m [256];
    longint hist [256];
    int taps = 1, dec = 1, dphase = 0;
    longint last_out;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    function automatic longint model();
        longint acc = 0;
        for (int k = 0; k < taps; k++) acc += longint'($signed(coef_m[k])) * hist[k];
        acc = (acc + (longint'(1) <<< 30)) >>> 31;
        if (acc > 8388607) acc = 8388607;
        if (acc < -8388608) acc = -8388608;
        return acc;
    endfunction

    task automatic push(input logic [23:0] x);
        for (int i = 255; i > 0; i--) hist[i] = hist[i-1];
        hist[0] = longint'($signed(x));
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); host_cs = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk); host_cs = 0; host_we = 0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); host_cs = 1; host_we = 0; host_addr = a;
        @(negedge clk); host_cs = 0;
        d = host_rdata;
    endtask

    task automatic write_decim(input int d);
        host_write(2, 8'(d - 1)); dec = d; dphase = 0;
    endtask

    task automatic set_cfg(input int t, input int d);
        host_write(1, 8'(t - 1)); taps = t;
        write_decim(d);
    endtask

    task automatic load_coefs(input int n);
        host_write(0, 8'd0);
        for (int t = 0; t < n; t++)
            for (int b = 0; b < 4; b++) host_write(3, coef_m[t][8*b +: 8]);
    endtask

    task automatic send_sample(input logic [23:0] x, input string req);
        bit trig, seen;
        int lat;
        longint exp;
        trig = (dphase == dec - 1);
        dphase = trig ? 0 : dphase + 1;
        @(negedge clk); in_valid = 1; in_sample = x;
        @(negedge clk); in_valid = 0;
        push(x);
        seen = 0; lat = 0;
        if (trig) begin
            exp = model();
            for (int c = 1; c <= taps + 4; c++) begin
                @(negedge clk);
                if (out_valid) begin seen = 1; lat = c; break; end
            end
            // R7: latency of N edges
            check(seen && lat == taps, "R7 latency", lat, taps);
            last_out = longint'($signed(out_sample));
            check(last_out == exp, req, last_out, exp);
        end else begin
            for (int c = 1; c <= taps + 3; c++) begin
                @(negedge clk);
                if (out_valid) seen = 1;
            end
            check(!seen, "R4 no output on non-trigger sample", seen, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] rb;
        longint expv;
        bit seen;
        rst = 1; in_valid = 0; in_sample = 0; host_cs = 0; host_we = 0;
        host_addr = 0; host_wdata = 0;
        for (int i = 0; i < 256; i++) begin hist[i] = 0; coef_m[i] = 0; end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: reset state
        check(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
        check(overrun == 0, "R1 overrun after reset", overrun, 0);
        host_read(1, rb); check(rb == 0, "R1 taps field", rb, 0);
        host_read(2, rb); check(rb == 0, "R1 decim field", rb, 0);
        send_sample(24'h123456, "R1 zero coefficients give zero");

        // R2/R3: coefficient load and read-back
        for (int t = 0; t < 8; t++) coef_m[t] = 32'($signed($urandom()) >>> 4);
        load_coefs(8);
        host_read(0, rb); check(rb == 8, "R2 pointer after 8 taps", rb, 8);
        host_write(0, 8'd5);
        for (int b = 0; b < 4; b++) begin
            host_read(3, rb);
            check(rb == coef_m[5][8*b +: 8], "R3 byte read-back order", rb, coef_m[5][8*b +: 8]);
        end
        host_read(0, rb); check(rb == 6, "R3 read advances pointer", rb, 6);

        // R5: random samples, N=8, D=1
        set_cfg(8, 1);
        host_read(1, rb); check(rb == 7, "R2 taps field read-back", rb, 7);
        for (int i = 0; i < 12; i++) send_sample(24'($urandom()), "R5 filter value N=8");

        // R4: decimation by 3, phase restart on decimation write
        set_cfg(8, 3);
        for (int i = 0; i < 9; i++) send_sample(24'($urandom()), "R4 decimated value D=3");
        send_sample(24'($urandom()), "R4 phase");
        write_decim(3);
        for (int i = 0; i < 3; i++) send_sample(24'($urandom()), "R4 value after phase restart");

        // R6: rounding of halves
        coef_m[0] = 32'h4000_0000;
        load_coefs(1);
        set_cfg(1, 1);
        send_sample(24'd1, "R6 round 0.5");        check(last_out == 1, "R6 0.5 -> 1", last_out, 1);
        send_sample(-24'sd1, "R6 round -0.5");     check(last_out == 0, "R6 -0.5 -> 0", last_out, 0);
        send_sample(24'd3, "R6 round 1.5");        check(last_out == 2, "R6 1.5 -> 2", last_out, 2);
        send_sample(-24'sd3, "R6 round -1.5");     check(last_out == -1, "R6 -1.5 -> -1", last_out, -1);

        // R6: saturation at both limits
        coef_m[0] = 32'h8000_0000; coef_m[1] = 32'h8000_0000;
        load_coefs(2);
        set_cfg(2, 1);
        send_sample(24'h800000, "R6 sat step");
        send_sample(24'h800000, "R6 positive saturation");
        check(last_out == 8388607, "R6 clamp high", last_out, 8388607);
        send_sample(24'h7FFFFF, "R6 sat step");
        send_sample(24'h7FFFFF, "R6 negative saturation");
        check(last_out == -8388608, "R6 clamp low", last_out, -8388608);

        // R5: full 256-tap filter, D=8
        for (int t = 0; t < 256; t++) coef_m[t] = 32'($signed($urandom()) >>> 8);
        load_coefs(256);
        set_cfg(256, 8);
        for (int i = 0; i < 16; i++) send_sample(24'($urandom()), "R5 filter value N=256");

        // R8: back-to-back samples
        set_cfg(8, 1);
        @(negedge clk); in_valid = 1; in_sample = 24'h0A0B0C;
        push(24'h0A0B0C); expv = model();
        @(negedge clk); in_sample = 24'hF00F00; push(24'hF00F00);
        @(negedge clk); in_valid = 0;
        seen = 0;
        for (int c = 0; c < 12; c++) begin
            if (out_valid) begin seen = 1; last_out = longint'($signed(out_sample)); end
            @(negedge clk);
        end
        check(seen && last_out == expv, "R8 pass unaffected by late sample", last_out, expv);
        check(overrun == 1, "R8 overrun raised", overrun, 1);
        host_read(2, rb); check(rb[7] == 1, "R8 overrun bit 7", rb[7], 1);
        write_decim(1);
        check(overrun == 0, "R8 cleared by decim write", overrun, 0);
        send_sample(24'h000777, "R8 late sample stored in history");

        done = 1;
        summary();
        $finish;
    end
endmodule